// File: doc/BRIEF.md
# Serial Converter Control and Power Sequencer

This block is the digital control side of a serial 8-bit sampling converter. With chip-select low it samples the data-in line on every clock. The first 1 it sees is taken as a start bit. The start bit and the bits that follow it form a control byte. Two fields of that byte set the conversion: a keep-powered flag and a clock-mode flag. Once the byte is complete, the block runs a conversion of fixed length. While the conversion runs, the strobe output is held low. At the end, the parallel sample input is loaded into an output shift register and the strobe returns high. The result is then clocked out MSB first.

The power state is set per conversion. If the keep-powered flag is 0, the block drops into software power-down once the conversion is done. If the flag is 1, the block stays powered. A start bit always wakes the block. While it is in software power-down, the serial interface still works, so the last result can still be read out. A shutdown input with three levels, encoded on two bits, can force a hard power-down at any time. This forced power-down cuts off a running conversion and returns the block to its reset state. The same shutdown input also decides whether the internal-reference enable is driven.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the strobe is high, powered_o is 1, dout_o is 0, and the block is in internal-clock mode.
- R2: A start bit is a 1 sampled on din_i while cs_ni is low. Ones sampled while cs_ni is high are ignored. The control byte is CTRL_W bits with the start bit as its MSB. The keep-powered flag is bit PD_POS (default 0). The clock-mode flag is bit MODE_POS (default 1), where 1 selects the internal clock.
- R3: The strobe falls at the clock edge that samples the last control bit. In internal-clock mode it then stays low for exactly CONV_CYCLES edges. It rises at the edge that loads sample_i into the output register.
- R4: Until the first conversion has completed, dout_o is 0.
- R5: After a conversion, dout_o shows the result MSB first. It advances one bit on each clock edge where cs_ni is low and no conversion is running. After the last bit it shows zeros.
- R6: If the keep-powered flag is 1, powered_o stays 1 after the conversion ends. If the flag is 0, powered_o falls at the edge that ends the conversion.
- R7: A start bit sets powered_o to 1 at the edge that samples it, including when the block is in software power-down.
- R8: During software power-down the result can still be shifted out, and clocking it out with din_i at 0 leaves powered_o at 0.
- R9: The shutdown input encodes low as 2'b00. While it is low, powered_o is 0 combinationally. At the next edge any conversion is abandoned, the strobe is high, and the state, including the result, returns to the reset state. After release, a new start bit is needed.
- R10: The reference enable ref_en_o is 1 when shutdown is floating (2'b10 or 2'b11). It is 0 when shutdown is high (2'b01) or low (2'b00). With shutdown high the block is otherwise fully enabled.
- R11: In external-clock mode (clock-mode flag 0), the conversion advances only on edges where cs_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; data-in is sampled on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| din_i | input | 1 | Serial data in (start bit and control byte) |
| shdn_i | input | 2 | Shutdown level: 00 low, 01 high, 10/11 floating |
| sample_i | input | RES_W | Conversion result, captured at the end of conversion |
| strobe_o | output | 1 | Low while a conversion is in progress |
| dout_o | output | 1 | Serial result out, MSB first |
| powered_o | output | 1 | 1 when the converter is powered |
| ref_en_o | output | 1 | Internal-reference enable |

## Verification
The bench drives inputs just after a falling edge and samples outputs 1 ns after the next rising edge.

- **Strobe low:** the first sample after the edge that takes the last control bit must show the strobe low.
- **Strobe high and result MSB:** in internal mode these are due after exactly CONV_CYCLES further edges. In external mode the bench first applies cs-high edges that must not count, and only then the counting edges.
- **Each later result bit:** due one cs-low edge after the previous bit.
- **powered_o:** it settles at the conversion-end edge, or at the start-bit edge when a start bit wakes the block, and is sampled there.
- **Shutdown:** powered_o and ref_en_o are combinational on shutdown, so they are checked 1 ns after shutdown is driven, before any edge. The abort is checked after the edge that follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SHDN_LOW       = 2'b00,
    SHDN_HIGH      = 2'b01,
    SHDN_FLOAT     = 2'b10,
    SHDN_FLOAT_ALT = 2'b11
  } shdn_e;

  localparam int unsigned NUM_FIELDS = 2;
  localparam int unsigned FLD_PD     = 0;
  localparam int unsigned FLD_MODE   = 1;
endpackage

// File: rtl/adc_shdn_dec.sv
module adc_shdn_dec
  import adc_seq_pkg::*;
(
  input  logic [1:0] shdn_i,
  output logic       hard_down_o,
  output logic       ref_en_o
);
  shdn_e lvl;

  always_comb begin
    lvl         = shdn_e'(shdn_i);
    hard_down_o = 1'b0;
    ref_en_o    = 1'b0;
    unique case (lvl)
      SHDN_LOW:                  hard_down_o = 1'b1;
      SHDN_HIGH:                 ref_en_o    = 1'b0;
      SHDN_FLOAT, SHDN_FLOAT_ALT: ref_en_o   = 1'b1;
      default:                   hard_down_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/adc_ctrl_rx.sv
module adc_ctrl_rx
  import adc_seq_pkg::*;
#(
  parameter int unsigned CTRL_W   = 8,
  parameter int unsigned PD_POS   = 0,
  parameter int unsigned MODE_POS = 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cs_ni,
  input  logic                  din_i,
  input  logic                  listen_i,
  output logic                  start_o,
  output logic                  byte_vld_o,
  output logic [NUM_FIELDS-1:0] fld_o
);
  localparam int unsigned NBITS = CTRL_W - 1;
  localparam int unsigned CNT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int unsigned FPOS [NUM_FIELDS] = '{PD_POS, MODE_POS};

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign start_o    = listen_i && !act_q && !cs_ni && din_i;
  assign take       = act_q && !cs_ni;
  assign byte_vld_o = take && (cnt_q == CNT_W'(NBITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_o) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (take) begin
      if (byte_vld_o) act_q <= 1'b0;
      else            cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // bit index arriving at count c is NBITS-1-c
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int unsigned AT = NBITS - 1 - FPOS[f];
    logic hit;
    logic val_q;
    assign hit = take && (cnt_q == CNT_W'(AT));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    val_q <= 1'b0;
      else if (clr_i) val_q <= 1'b0;
      else if (hit)   val_q <= din_i;
    end
    assign fld_o[f] = hit ? din_i : val_q;
  end

  assert_byte_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    byte_vld_o |=> !act_q);
  assert_start_arms_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    start_o |=> (act_q && cnt_q == '0));
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cs_ni,
  input  logic start_i,
  input  logic byte_vld_i,
  input  logic pd_i,
  input  logic mode_i,
  output logic busy_o,
  output logic done_o,
  output logic pwr_o
);
  localparam int unsigned CC_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CC_W-1:0] LAST = CC_W'(CONV_CYCLES - 1);

  logic            conv_q;
  logic [CC_W-1:0] cnt_q;
  logic            int_q;
  logic            pd_q;
  logic            pwr_q;
  logic            adv;

  assign adv    = int_q || !cs_ni;
  assign done_o = conv_q && adv && (cnt_q == LAST);
  assign busy_o = conv_q;
  assign pwr_o  = pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= 1'b0;
      cnt_q  <= '0;
      int_q  <= 1'b1;
      pd_q   <= 1'b0;
      pwr_q  <= 1'b1;
    end else if (clr_i) begin
      conv_q <= 1'b0;
      cnt_q  <= '0;
      int_q  <= 1'b1;
      pd_q   <= 1'b0;
      pwr_q  <= 1'b1;
    end else begin
      if (byte_vld_i) begin
        conv_q <= 1'b1;
        cnt_q  <= '0;
        int_q  <= mode_i;
        pd_q   <= pd_i;
      end else if (done_o) begin
        conv_q <= 1'b0;
        pwr_q  <= pd_q;
      end else if (conv_q && adv) begin
        cnt_q <= cnt_q + CC_W'(1);
      end
      if (start_i) pwr_q <= 1'b1;
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_q |-> (cnt_q <= LAST));
  assert_conv_starts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    byte_vld_i |=> (conv_q && cnt_q == '0));
  assert_pd0_sleep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (done_o && !pd_q) |=> !pwr_q);
  assert_pd1_awake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (done_o && pd_q) |=> pwr_q);
  assert_ext_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (conv_q && !int_q && cs_ni) |=> $stable(cnt_q));
  assert_wake_R7: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    start_i |=> pwr_q);
endmodule

// File: rtl/adc_dout_sreg.sv
module adc_dout_sreg #(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [RES_W-1:0] data_i,
  output logic             dout_o
);
  logic [RES_W-1:0] sr_q;
  logic             has_res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= '0;
      has_res_q <= 1'b0;
    end else if (clr_i) begin
      sr_q      <= '0;
      has_res_q <= 1'b0;
    end else if (load_i) begin
      sr_q      <= data_i;
      has_res_q <= 1'b1;
    end else if (shift_i) begin
      sr_q <= {sr_q[RES_W-2:0], 1'b0};
    end
  end

  assign dout_o = sr_q[RES_W-1];

  assert_zero_before_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !has_res_q |-> !dout_o);
  assert_load_msb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    load_i |=> (dout_o == $past(data_i[RES_W-1])));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned RES_W       = 8,
  parameter int unsigned CONV_CYCLES = 8,
  parameter int unsigned PD_POS      = 0,
  parameter int unsigned MODE_POS    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             din_i,
  input  logic [1:0]       shdn_i,
  input  logic [RES_W-1:0] sample_i,
  output logic             strobe_o,
  output logic             dout_o,
  output logic             powered_o,
  output logic             ref_en_o
);
  logic                  hard_down;
  logic                  start;
  logic                  byte_vld;
  logic [NUM_FIELDS-1:0] fld;
  logic                  busy;
  logic                  done;
  logic                  pwr;

  adc_shdn_dec u_shdn (
    .shdn_i      (shdn_i),
    .hard_down_o (hard_down),
    .ref_en_o    (ref_en_o)
  );

  adc_ctrl_rx #(
    .CTRL_W   (CTRL_W),
    .PD_POS   (PD_POS),
    .MODE_POS (MODE_POS)
  ) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (hard_down),
    .cs_ni      (cs_ni),
    .din_i      (din_i),
    .listen_i   (!busy),
    .start_o    (start),
    .byte_vld_o (byte_vld),
    .fld_o      (fld)
  );

  adc_conv_seq #(
    .CONV_CYCLES (CONV_CYCLES)
  ) u_conv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (hard_down),
    .cs_ni      (cs_ni),
    .start_i    (start),
    .byte_vld_i (byte_vld),
    .pd_i       (fld[FLD_PD]),
    .mode_i     (fld[FLD_MODE]),
    .busy_o     (busy),
    .done_o     (done),
    .pwr_o      (pwr)
  );

  adc_dout_sreg #(
    .RES_W (RES_W)
  ) u_sreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hard_down),
    .load_i  (done),
    .shift_i (!cs_ni && !busy),
    .data_i  (sample_i),
    .dout_o  (dout_o)
  );

  assign strobe_o  = !busy;
  assign powered_o = pwr && !hard_down;

  assert_hard_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_down |=> (strobe_o && !dout_o));
  assert_no_ref_in_down_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !powered_o && pwr |-> !ref_en_o);
endmodule

// File: tb/tb_adc_seq_ctrl.sv
`timescale 1ns/1ps
module tb_adc_seq_ctrl;
  localparam int CONV = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n;
  logic       din;
  logic [1:0] shdn;
  logic [7:0] sample;
  logic       strobe, dout, powered, ref_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #5 clk = ~clk;

  adc_seq_ctrl dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .din_i     (din),
    .shdn_i    (shdn),
    .sample_i  (sample),
    .strobe_o  (strobe),
    .dout_o    (dout),
    .powered_o (powered),
    .ref_en_o  (ref_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic tick(input logic c, input logic d);
    @(negedge clk);
    cs_n = c;
    din  = d;
    @(posedge clk);
    #1;
  endtask

  // start bit, five zero bits, mode bit, keep-powered bit
  task automatic send_byte(input logic mode, input logic pd, input bit first);
    tick(1'b0, 1'b1);
    check("R7 wake on start", powered, 1'b1);
    for (int i = 0; i < 5; i++) begin
      tick(1'b0, 1'b0);
      check("R3 strobe high during byte", strobe, 1'b1);
      if (first) check("R4 zeros before result", dout, 1'b0);
    end
    tick(1'b0, mode);
    check("R3 strobe high before last bit", strobe, 1'b1);
    tick(1'b0, pd);
    check("R3 strobe low after last bit", strobe, 1'b0);
  endtask

  task automatic run_conv(input logic [7:0] val, input logic pd, input logic mode, input bit first);
    sample = val;
    send_byte(mode, pd, first);
    if (mode) begin
      for (int i = 0; i < CONV - 1; i++) begin
        tick(1'b1, 1'b0);
        check("R3 strobe low in conversion", strobe, 1'b0);
      end
      tick(1'b1, 1'b0);
      check("R3 strobe high at end", strobe, 1'b1);
    end else begin
      for (int i = 0; i < 3; i++) begin
        tick(1'b1, 1'b0);
        check("R11 cs high does not advance", strobe, 1'b0);
      end
      for (int i = 0; i < CONV - 1; i++) begin
        tick(1'b0, 1'b0);
        check("R11 strobe low in ext conversion", strobe, 1'b0);
      end
      tick(1'b0, 1'b0);
      check("R11 strobe high after CONV cs-low edges", strobe, 1'b1);
    end
    check("R6 power after conversion", powered, pd);
    for (int b = 7; b >= 0; b--) begin
      check(pd ? "R5 result bit" : "R8 result bit in power-down", dout, val[b]);
      tick(1'b0, 1'b0);
    end
    check("R5 zeros after result", dout, 1'b0);
    check("R8 readout leaves power state", powered, pd);
  endtask

  initial begin
    rst_n  = 1'b0;
    cs_n   = 1'b1;
    din    = 1'b0;
    shdn   = 2'b10;
    sample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 strobe after reset", strobe, 1'b1);
    check("R1 powered after reset", powered, 1'b1);
    check("R1 dout after reset", dout, 1'b0);
    check("R10 float enables ref", ref_en, 1'b1);

    @(negedge clk); shdn = 2'b01; #1;
    check("R10 high disables ref", ref_en, 1'b0);
    check("R10 high keeps power", powered, 1'b1);
    @(negedge clk); shdn = 2'b11; #1;
    check("R10 alt float enables ref", ref_en, 1'b1);
    @(negedge clk); shdn = 2'b00; #1;
    check("R10 low disables ref", ref_en, 1'b0);
    check("R9 low forces power off", powered, 1'b0);
    @(negedge clk); shdn = 2'b10; #1;

    for (int i = 0; i < 3; i++) begin
      tick(1'b1, 1'b1);
      check("R2 ones with cs high ignored", strobe, 1'b1);
    end
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0);
      check("R2 zeros are not a start", strobe, 1'b1);
      check("R4 zeros before result", dout, 1'b0);
    end

    // R1: first conversion in internal mode default; sweep values and modes
    run_conv(8'hA5, 1'b1, 1'b1, 1'b1);
    for (int s = 0; s < 32; s++) begin
      logic [7:0] v;
      v = 8'((s * 37 + 11) ^ (s << 3));
      run_conv(v, s[0], s[1], 1'b0);
    end
    run_conv(8'hFF, 1'b0, 1'b1, 1'b0);
    run_conv(8'h00, 1'b1, 1'b0, 1'b0);
    run_conv(8'h81, 1'b0, 1'b0, 1'b0);

    // hard shutdown mid-conversion
    sample = 8'hC3;
    send_byte(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b0);
    check("R3 strobe low before abort", strobe, 1'b0);
    @(negedge clk); shdn = 2'b00; #1;
    check("R9 powered drops at once", powered, 1'b0);
    @(posedge clk); #1;
    check("R9 strobe high after abort", strobe, 1'b1);
    check("R9 result cleared", dout, 1'b0);
    @(negedge clk); shdn = 2'b10;
    for (int i = 0; i < CONV + 2; i++) begin
      tick(1'b1, 1'b0);
      check("R9 no conversion resumes", strobe, 1'b1);
    end
    check("R9 reset state powered", powered, 1'b1);
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 1'b0);
      check("R9 fresh start bit needed", strobe, 1'b1);
      check("R9 output stays zero", dout, 1'b0);
    end
    run_conv(8'h3C, 1'b0, 1'b1, 1'b1);
    run_conv(8'h96, 1'b1, 1'b1, 1'b0);
    finish_run();
  end
endmodule